// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block produces the high-side and low-side gate enables for one phase of a synchronous buck converter. Its input is a PWM request. A handover never runs on a fixed dead time. Before the block turns on the opposite switch, it waits for a digital flag from an analog comparator. When the high-side turns off, the block waits for the switch node to fall below its threshold. When the low-side turns off, it waits for the sensed low-side gate voltage to fall below its threshold. In both cases a short settling delay, counted in system clock cycles, follows the flag.

Negative inductor current can hold the switch node high. To cover that case, a watchdog turns the low-side on anyway once a bounded wait has passed, so the current can recirculate. A valley overcurrent flag keeps the low-side conducting and skips high-side pulses. A crowbar command latches the phase into low-side-on. A force-off command opens both switches for as long as it is held. All delays are parameters in units of a 100 MHz clock: 3 cycles for each settling delay and 24 cycles for the watchdog.

Top module: `deadtime_gate_seq`

## Requirements
- R1: While `rst_n` is low, both enables are low at once (asynchronous). Reset also clears the crowbar latch and the overcurrent skip. After reset is released, a PWM request high can bring the high-side on again.
- R2: After `hs_en` falls, `ls_en` rises at exactly the LS_DLY_CYC-th rising edge. The count starts at the first edge after the fall that samples `sw_low` high, and that edge counts as 1. A `sw_low` pulse that has since ended still counts.
- R3: If `sw_low` is never sampled high after `hs_en` falls, `ls_en` rises at the WD_CYC-th rising edge after the edge at which `hs_en` fell.
- R4: With `ls_en` high, the first edge that samples `pwm_req` high (with no overcurrent skip and no crowbar) drops `ls_en`. `hs_en` then rises at the HS_DLY_CYC-th edge, counted from the first later edge that samples `lsg_low` high.
- R5: `hs_en` and `ls_en` are never high in the same cycle.
- R6: An edge that samples `valley_oc` high keeps `ls_en` high and `hs_en` low. After `valley_oc` clears, the skip holds until an edge samples `pwm_req` low. The next high request then starts a normal high-side turn-on.
- R7: An edge that samples `force_ls` high takes `hs_en` low at that edge. `ls_en` then turns on through the R2/R3 handover and stays high whatever `pwm_req` does, until reset. After a force-off is released, the block returns to low-side-on through R2/R3.
- R8: An edge that samples `force_off` high drives both enables low, whatever the state. They stay low while it is held, and it overrides `force_ls`.
- R9: If a PWM request arrives while the block is waiting to turn on the low-side, `ls_en` still turns on and stays high for at least one cycle before it drops.
- R10: If `pwm_req` is sampled low while the block is waiting to turn on the high-side, `ls_en` returns high at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz assumed for the delay counts) |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| pwm_req | input | 1 | 1 requests the high-side on, 0 requests the low-side on |
| sw_low | input | 1 | 1 when the switch node is below its threshold |
| lsg_low | input | 1 | 1 when the low-side gate voltage is below its threshold |
| valley_oc | input | 1 | 1 when the valley current comparator reports overcurrent |
| force_off | input | 1 | 1 forces both switches off (inhibit) |
| force_ls | input | 1 | 1 latches the crowbar: high-side off, low-side held on |
| hs_en | output | 1 | High-side gate enable, registered |
| ls_en | output | 1 | Low-side gate enable, registered |

## Verification
Both enables come straight from registers. A wrong state therefore shows at the ports on the very next edge: an enable appears early, a pulse is lost, or the two overlap. A settling counter that is off by one moves the turn-on edge by exactly one cycle. A stuck watchdog stretches the gap where both enables are low past 24 cycles. A crowbar or skip latch that is not held lets `hs_en` come back on a later PWM request, and a latch that does not clear leaves it off. The bench steps through whole switching cycles with known edge counts and samples every cycle. An error in any of these states therefore shows up within a few cycles of the event that caused it.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

  // Phase sequencing states; GS_IDLE holds both switches open.
  typedef enum logic [2:0] {
    GS_IDLE    = 3'd0,
    GS_HS_ON   = 3'd1,
    GS_WAIT_LS = 3'd2,
    GS_LS_ON   = 3'd3,
    GS_WAIT_HS = 3'd4
  } gs_state_e;

endpackage

// File: rtl/gseq_rst_sync.sv
module gseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  // Assert asynchronously, release after STAGES clock edges.
  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/gseq_wait_timer.sv
module gseq_wait_timer #(
  parameter int unsigned DLY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic flag,
  output logic seen,
  output logic done
);

  logic armed_q;
  logic arm_en;

  // The flag is remembered once seen during the active window.
  assign seen   = armed_q | flag;
  assign arm_en = active & flag & ~armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (!active) begin
      armed_q <= 1'b0;
    end else if (arm_en) begin
      armed_q <= 1'b1;
    end
  end

  generate
    if (DLY <= 1) begin : g_direct
      // Done on the sampling edge itself.
      assign done = active & seen;
    end else begin : g_count
      localparam int unsigned CW = $clog2(DLY);
      localparam logic [CW-1:0] LAST = CW'(DLY - 1);

      logic [CW-1:0] cnt_q;
      logic          cnt_en;

      assign cnt_en = active & seen & (cnt_q != LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (!active) begin
          cnt_q <= '0;
        end else if (cnt_en) begin
          cnt_q <= cnt_q + CW'(1);
        end
      end

      // The edge that first samples the flag counts as edge 1.
      assign done = active & seen & (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/deadtime_gate_seq.sv
module deadtime_gate_seq
  import gseq_pkg::*;
#(
  parameter int unsigned LS_DLY_CYC = 3,
  parameter int unsigned HS_DLY_CYC = 3,
  parameter int unsigned WD_CYC     = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_req,
  input  logic sw_low,
  input  logic lsg_low,
  input  logic valley_oc,
  input  logic force_off,
  input  logic force_ls,
  output logic hs_en,
  output logic ls_en
);

  logic      rst_core_n;
  gs_state_e state_q;
  gs_state_e state_d;
  logic      clamp_q;
  logic      clamp_set;
  logic      clamp_hold;
  logic      skip_q;
  logic      skip_d;
  logic      hs_allowed;
  logic      in_wait_ls;
  logic      in_wait_hs;
  logic      ls_seen;
  logic      ls_go;
  logic      hs_seen;
  logic      hs_go;
  logic      wd_seen;
  logic      wd_done;
  logic      wd_fire;
  logic      hs_q;
  logic      ls_q;

  gseq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_core_n)
  );

  assign in_wait_ls = (state_q == GS_WAIT_LS);
  assign in_wait_hs = (state_q == GS_WAIT_HS);

  // Switch node fall qualifier plus settling delay.
  gseq_wait_timer #(.DLY(LS_DLY_CYC)) u_ls_delay (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .active (in_wait_ls),
    .flag   (sw_low),
    .seen   (ls_seen),
    .done   (ls_go)
  );

  // Low-side gate discharge qualifier plus settling delay.
  gseq_wait_timer #(.DLY(HS_DLY_CYC)) u_hs_delay (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .active (in_wait_hs),
    .flag   (lsg_low),
    .seen   (hs_seen),
    .done   (hs_go)
  );

  // Negative-current watchdog: free-running count of the low-side wait.
  gseq_wait_timer #(.DLY(WD_CYC)) u_watchdog (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .active (in_wait_ls),
    .flag   (1'b1),
    .seen   (wd_seen),
    .done   (wd_done)
  );

  // Watchdog only acts when the switch node never fell.
  assign wd_fire    = wd_done & wd_seen & ~ls_seen;

  assign clamp_set  = force_ls & ~clamp_q;
  assign clamp_hold = clamp_q | force_ls;
  assign skip_d     = valley_oc | (skip_q & pwm_req);
  assign hs_allowed = pwm_req & ~valley_oc & ~skip_q & ~clamp_hold;

  always_comb begin
    state_d = state_q;
    if (force_off) begin
      state_d = GS_IDLE;
    end else begin
      unique case (state_q)
        GS_IDLE: begin
          state_d = hs_allowed ? GS_WAIT_HS : GS_WAIT_LS;
        end
        GS_HS_ON: begin
          if (!pwm_req || clamp_hold) begin
            state_d = GS_WAIT_LS;
          end
        end
        GS_WAIT_LS: begin
          if (ls_go || wd_fire) begin
            state_d = GS_LS_ON;
          end
        end
        GS_LS_ON: begin
          if (hs_allowed) begin
            state_d = GS_WAIT_HS;
          end
        end
        GS_WAIT_HS: begin
          if (!hs_allowed) begin
            state_d = GS_LS_ON;
          end else if (hs_go && hs_seen) begin
            state_d = GS_HS_ON;
          end
        end
        default: begin
          state_d = GS_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= GS_IDLE;
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hs_q    <= (state_d == GS_HS_ON);
      ls_q    <= (state_d == GS_LS_ON);
      skip_q  <= skip_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      clamp_q <= 1'b0;
    end else if (clamp_set) begin
      clamp_q <= 1'b1;
    end
  end

  assign hs_en = hs_q;
  assign ls_en = ls_q;

endmodule

// File: rtl/gseq_checker.sv
module gseq_checker #(
  parameter int unsigned WD_CYC = 24
) (
  input logic clk,
  input logic rst_n,
  input logic hs_en,
  input logic ls_en,
  input logic force_off,
  input logic force_ls,
  input logic valley_oc,
  input logic clamp_q
);

  localparam int unsigned TW = $clog2(WD_CYC + 2) + 1;

  logic          trk_q;
  logic [TW-1:0] gap_q;

  // Length of the both-off gap that follows a high-side turn-off.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_q <= 1'b0;
      gap_q <= '0;
    end else if (force_off || hs_en || ls_en) begin
      trk_q <= hs_en & ~force_off;
      gap_q <= '0;
    end else if (trk_q) begin
      gap_q <= gap_q + TW'(1);
    end
  end

  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  assert_wd_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= TW'(WD_CYC));

  assert_ls_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> !$past(hs_en));

  assert_hs_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> !$past(ls_en));

  assert_oc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_en && valley_oc && !force_off) |=> ls_en);

  assert_clamp_hs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ls && !force_off) |=> !hs_en);

  assert_clamp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_q && ls_en && !force_off) |=> ls_en);

  assert_force_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> (!hs_en && !ls_en));

endmodule

bind deadtime_gate_seq gseq_checker #(.WD_CYC(WD_CYC)) u_gseq_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .hs_en     (hs_en),
  .ls_en     (ls_en),
  .force_off (force_off),
  .force_ls  (force_ls),
  .valley_oc (valley_oc),
  .clamp_q   (clamp_q)
);

// File: tb/tb_deadtime_gate_seq.sv
module tb_deadtime_gate_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WD         = 24;
  localparam int NVEC       = 44;

  // {pwm, sw_low, lsg_low, valley_oc, force_off, force_ls, exp_hs, exp_ls}
  localparam logic [7:0] VEC [0:NVEC-1] = '{
    8'b0000_0000, 8'b0100_0000, 8'b0100_0000, 8'b0100_0001,
    8'b1100_0000, 8'b1000_0000, 8'b1010_0000, 8'b1010_0000,
    8'b1010_0010, 8'b1010_0010, 8'b0000_0000, 8'b0000_0000,
    8'b0100_0000, 8'b0000_0000, 8'b0000_0001, 8'b1010_0000,
    8'b1010_0000, 8'b1010_0000, 8'b1010_0010, 8'b0000_0000,
    8'b1100_0000, 8'b1100_0000, 8'b1100_0001, 8'b1000_0000,
    8'b1010_0000, 8'b1010_0000, 8'b1010_0010, 8'b0000_0000,
    8'b0100_0000, 8'b0100_0000, 8'b0100_0001, 8'b1001_0001,
    8'b1000_0001, 8'b0000_0001, 8'b1010_0000, 8'b1010_0000,
    8'b1010_0000, 8'b1010_0010, 8'b0100_0000, 8'b0100_0000,
    8'b0100_0000, 8'b0100_0001, 8'b1000_0000, 8'b0000_0001
  };

  logic clk;
  logic rst_n;
  logic pwm_req;
  logic sw_low;
  logic lsg_low;
  logic valley_oc;
  logic force_off;
  logic force_ls;
  logic hs_en;
  logic ls_en;

  int checks = 0;
  int fails  = 0;
  int overlap_cnt = 0;
  bit finished = 1'b0;

  deadtime_gate_seq #(
    .LS_DLY_CYC (3),
    .HS_DLY_CYC (3),
    .WD_CYC     (WD)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_req   (pwm_req),
    .sw_low    (sw_low),
    .lsg_low   (lsg_low),
    .valley_oc (valley_oc),
    .force_off (force_off),
    .force_ls  (force_ls),
    .hs_en     (hs_en),
    .ls_en     (ls_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // R5 monitor: sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && hs_en === 1'b1 && ls_en === 1'b1) overlap_cnt++;
  end

  function automatic string row_tag(input int i);
    if (i < 4)       return "R2";
    else if (i < 10) return "R4";
    else if (i < 15) return "R2";
    else if (i < 19) return "R4";
    else if (i < 27) return "R9";
    else if (i < 31) return "R2";
    else if (i < 38) return "R6";
    else if (i < 42) return "R2";
    else             return "R10";
  endfunction

  task automatic check(input string tag, input logic exp_hs, input logic exp_ls);
    checks++;
    if (hs_en !== exp_hs || ls_en !== exp_ls) begin
      fails++;
      $display("FAIL %s: hs_en/ls_en = %b%b, expected %b%b at %0t",
               tag, hs_en, ls_en, exp_hs, exp_ls, $time);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic apply(input logic p, input logic s, input logic g,
                       input logic o, input logic fo, input logic fl);
    pwm_req   = p;
    sw_low    = s;
    lsg_low   = g;
    valley_oc = o;
    force_off = fo;
    force_ls  = fl;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung, expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pwm_req = 1'b0; sw_low = 1'b0; lsg_low = 1'b0;
    valley_oc = 1'b0; force_off = 1'b0; force_ls = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      check("R8", 1'b0, 1'b0);
    end

    // Table walk.
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      check(row_tag(i), VEC[i][1], VEC[i][0]);
    end

    // R3: negative current, switch node never falls.
    for (int k = 0; k < 4; k++) apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R4", 1'b1, 1'b0);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R3", 1'b0, 1'b0);
    for (int k = 0; k < WD - 1; k++) apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R3", 1'b0, 1'b0);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R3", 1'b0, 1'b1);

    // R7: crowbar from high-side on.
    for (int k = 0; k < 4; k++) apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R4", 1'b1, 1'b0);
    apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R7", 1'b0, 1'b0);
    for (int k = 0; k < 2; k++) apply(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R7", 1'b0, 1'b0);
    apply(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R7", 1'b0, 1'b1);
    for (int k = 0; k < 6; k++) begin
      apply(k[0], 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      check("R7", 1'b0, 1'b1);
    end

    // R8: force-off overrides the latched crowbar, R7 latch survives it.
    for (int k = 0; k < 3; k++) begin
      apply(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
      check("R8", 1'b0, 1'b0);
    end
    for (int k = 0; k < 3; k++) apply(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R7", 1'b0, 1'b0);
    apply(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R7", 1'b0, 1'b1);

    // R1: asynchronous reset mid-run clears the crowbar.
    rst_n = 1'b0;
    #1;
    check("R1", 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R1", 1'b0, 1'b0);
    apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R1", 1'b1, 1'b0);

    // R8: force-off straight from high-side on.
    apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R8", 1'b0, 1'b0);

    // R5: no overlap over the whole run.
    checks++;
    if (overlap_cnt != 0) begin
      fails++;
      $display("FAIL R5: overlap cycles = %0d, expected 0", overlap_cnt);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule